// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block turns 32-bit virtual addresses into physical addresses through a fully associative translation cache. Each entry is tagged with the identifier of the address space that owns it, so the cache does not have to be emptied when the running process changes. Before any tag comparison, the three most significant address bits select one of four regions. Two regions are mapped through the cache: the user region and a mapped kernel region. The other two regions pass straight through as direct kernel windows, one cached and one uncached.

A lookup returns, one clock after the request, either a physical address with its cacheable attribute or exactly one failure: a miss, a modify/protection fault or an address fault. The block never walks page tables. Software reacts to a miss by writing a new entry through the refill port. It can place that entry at an index of its choice, or in a slot picked by a free-running victim counter. The same port removes single entries, and a flush input empties the whole cache in one cycle.

Top module: `asid_tlb`

## Requirements
- R1: An address whose bits [31:29] are 100 or 101, issued in kernel mode, does not use the entries. The physical address is the virtual address with bits [31:29] cleared. The cacheable flag is 1 for 100 and 0 for 101, and hit, miss and both fault flags stay 0.
- R2: An address whose bit 31 is 0 (user region), or whose bits [31:30] are 11 (mapped kernel region), is compared in parallel against every entry. A valid entry whose 6-bit identifier equals the request identifier and whose 20-bit page number equals address bits [31:12] gives a hit. The hit returns {entry page frame, address bits [11:0]}, and the cacheable flag is the inverse of the entry's no-cache bit.
- R3: A mapped-region lookup that matches no valid entry raises the miss flag, with a physical address of 0 and the cacheable flag at 0.
- R4: A write lookup that matches an entry whose rights bit is 0 (read-only), or whose dirty bit is 0, raises the modify fault instead of a hit, with a physical address of 0. A read lookup of the same entry hits.
- R5: In user mode, any address with bit 31 set raises the address fault, with a physical address of 0. This takes precedence over every other outcome.
- R6: An indexed refill (write enable with random select at 0) replaces the whole entry at the given index. Writing an entry with its valid bit at 0 invalidates that slot.
- R7: A random refill writes the slot named by a 6-bit victim counter. The counter is 0 in the first cycle after reset and advances by one every clock, wrapping from 63 to 0.
- R8: A flush clears the valid bit of every entry in one cycle. A refill presented in the same cycle is discarded.
- R9: When several valid entries match, the lowest-indexed one supplies the translation, and the multi-hit flag is raised together with the hit flag.
- R10: A request sampled at a clock edge has its result on the outputs right after that edge, marked by the response-valid flag. A refill takes effect only for requests sampled at later edges. In a cycle with no request, every output is 0.
- R11: Reset empties all entries and drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| req_user_mode | input | 1 | Requester runs in user mode |
| req_asid | input | 6 | Current address-space identifier |
| wr_en | input | 1 | Refill write strobe |
| wr_random | input | 1 | Use the victim counter instead of wr_index |
| wr_index | input | 6 | Target slot for an indexed refill |
| wr_valid | input | 1 | Valid bit of the written entry |
| wr_asid | input | 6 | Identifier of the written entry |
| wr_vpn | input | 20 | Virtual page number of the written entry |
| wr_ppn | input | 20 | Physical frame of the written entry |
| wr_dirty | input | 1 | Dirty (writes allowed) bit |
| wr_rw | input | 1 | 1 = read/write, 0 = read-only |
| wr_nocache | input | 1 | 1 = page is uncached |
| flush_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Result of the previous-cycle request |
| rsp_paddr | output | 32 | Physical address |
| rsp_cacheable | output | 1 | Access may be cached |
| rsp_hit | output | 1 | Translation delivered from an entry |
| rsp_miss | output | 1 | No matching entry |
| rsp_mod_fault | output | 1 | Store to read-only or clean page |
| rsp_addr_fault | output | 1 | User access to a kernel region |
| rsp_multi_hit | output | 1 | More than one entry matched |

## Verification
Every lookup result is due one edge after the request is sampled. The bench drives on the falling edge and compares the full response on the following falling edge, after exactly one rising edge. Refills and flushes are driven one falling edge ahead of any lookup that relies on them. One directed case places a refill and a lookup on the same edge and expects the old contents. The bench tracks the victim counter by counting rising edges from reset, so the slot of each random refill is known when it is driven.

// File: rtl/asid_tlb_pkg.sv
// Shared widths, entry layout and region codes for the translation cache.
// Assumes physical and virtual addresses have the same width.
package asid_tlb_pkg;
    parameter int VA_W   = 32;
    parameter int PA_W   = 32;
    parameter int PAGE_W = 12;
    parameter int ASID_W = 6;
    localparam int VPN_W = VA_W - PAGE_W;
    localparam int PPN_W = PA_W - PAGE_W;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic              dirty;
        logic              rw;
        logic              nocache;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        RG_USER      = 2'd0,
        RG_KDIRECT_C = 2'd1,
        RG_KDIRECT_U = 2'd2,
        RG_KMAPPED   = 2'd3
    } region_e;
endpackage

// File: rtl/asid_tlb_region.sv
// Region decoder: classifies an address by its three top bits, flags user
// access to kernel space and forms the pass-through address for the direct
// kernel windows. Purely combinational.
module asid_tlb_region
    import asid_tlb_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    input  logic            user_mode,
    output region_e         region,
    output logic            mapped,
    output logic            addr_fault,
    output logic [PA_W-1:0] bypass_paddr,
    output logic            bypass_cacheable
);
    logic [2:0] top3;

    // Decode the region and its attributes from the top address bits.
    always_comb begin
        top3 = vaddr[VA_W-1 -: 3];
        casez (top3)
            3'b0??:  region = RG_USER;
            3'b100:  region = RG_KDIRECT_C;
            3'b101:  region = RG_KDIRECT_U;
            default: region = RG_KMAPPED;
        endcase
        mapped           = (region == RG_USER) || (region == RG_KMAPPED);
        addr_fault       = user_mode && (region != RG_USER);
        bypass_paddr     = PA_W'(vaddr[VA_W-4:0]);
        bypass_cacheable = (region == RG_KDIRECT_C);
    end
endmodule

// File: rtl/asid_tlb_store.sv
// Entry storage with refill port, one-cycle flush and free-running victim
// counter. Flush wins over a refill in the same cycle. Assumes a refill and a
// lookup in one cycle may see the old contents.
module asid_tlb_store
    import asid_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_random,
    input  logic [IDX_W-1:0]         wr_index,
    input  tlb_entry_t               wr_entry,
    input  logic                     flush_all,
    output tlb_entry_t [ENTRIES-1:0] entries
);
    logic [IDX_W-1:0] victim_q;
    logic [IDX_W-1:0] slot;

    // Pick the slot a refill targets.
    always_comb slot = wr_random ? victim_q : wr_index;

    // Advance the victim counter every cycle, wrapping at the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            victim_q <= '0;
        else if (victim_q == IDX_W'(ENTRIES - 1))
            victim_q <= '0;
        else
            victim_q <= victim_q + 1'b1;
    end

    // Hold the entries: clear on reset, drop valid bits on flush, else refill.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n)
                entries[i] <= '0;
            else if (flush_all)
                entries[i].valid <= 1'b0;
            else if (wr_en && (slot == IDX_W'(i)))
                entries[i] <= wr_entry;
        end
    end
endmodule

// File: rtl/asid_tlb_match.sv
// Parallel tag comparison over all entries with lowest-index priority and
// multi-match detection. Purely combinational.
module asid_tlb_match
    import asid_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
)(
    input  tlb_entry_t [ENTRIES-1:0] entries,
    input  logic [ASID_W-1:0]        asid,
    input  logic [VPN_W-1:0]         vpn,
    output logic                     any_hit,
    output logic                     multi_hit,
    output logic [PPN_W-1:0]         hit_ppn,
    output logic                     hit_rw,
    output logic                     hit_dirty,
    output logic                     hit_nocache
);
    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   sel;

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = entries[g].valid &&
                            (entries[g].asid == asid) &&
                            (entries[g].vpn == vpn);
    end

    // Lowest matching index wins; flag more than one match.
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel = IDX_W'(i);
        end
        any_hit     = |hit_vec;
        multi_hit   = |(hit_vec & (hit_vec - ENTRIES'(1)));
        hit_ppn     = entries[sel].ppn;
        hit_rw      = entries[sel].rw;
        hit_dirty   = entries[sel].dirty;
        hit_nocache = entries[sel].nocache;
    end
endmodule

// File: rtl/asid_tlb.sv
// Top of the identifier-tagged translation cache. Decodes the region, looks up
// mapped addresses, resolves faults by priority (address fault, bypass, miss,
// modify fault, hit) and registers the result one cycle after the request.
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_user_mode,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              wr_en,
    input  logic              wr_random,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic              wr_valid,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic              wr_dirty,
    input  logic              wr_rw,
    input  logic              wr_nocache,
    input  logic              flush_all,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_cacheable,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_mod_fault,
    output logic              rsp_addr_fault,
    output logic              rsp_multi_hit
);
    tlb_entry_t                   wr_entry;
    tlb_entry_t [NUM_ENTRIES-1:0] entries;
    region_e                      region;
    logic                         mapped, addr_fault, bypass_cacheable;
    logic [PA_W-1:0]              bypass_paddr;
    logic                         any_hit, multi_hit, hit_rw, hit_dirty, hit_nocache;
    logic [PPN_W-1:0]             hit_ppn;

    logic            n_valid, n_cache, n_hit, n_miss, n_mod, n_af, n_multi;
    logic [PA_W-1:0] n_paddr;

    // Assemble the refill entry from the write port.
    always_comb begin
        wr_entry.valid   = wr_valid;
        wr_entry.asid    = wr_asid;
        wr_entry.vpn     = wr_vpn;
        wr_entry.ppn     = wr_ppn;
        wr_entry.dirty   = wr_dirty;
        wr_entry.rw      = wr_rw;
        wr_entry.nocache = wr_nocache;
    end

    asid_tlb_region u_region (
        .vaddr            (req_vaddr),
        .user_mode        (req_user_mode),
        .region           (region),
        .mapped           (mapped),
        .addr_fault       (addr_fault),
        .bypass_paddr     (bypass_paddr),
        .bypass_cacheable (bypass_cacheable)
    );

    asid_tlb_store #(.ENTRIES(NUM_ENTRIES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_random (wr_random),
        .wr_index  (wr_index),
        .wr_entry  (wr_entry),
        .flush_all (flush_all),
        .entries   (entries)
    );

    asid_tlb_match #(.ENTRIES(NUM_ENTRIES)) u_match (
        .entries     (entries),
        .asid        (req_asid),
        .vpn         (req_vaddr[VA_W-1:PAGE_W]),
        .any_hit     (any_hit),
        .multi_hit   (multi_hit),
        .hit_ppn     (hit_ppn),
        .hit_rw      (hit_rw),
        .hit_dirty   (hit_dirty),
        .hit_nocache (hit_nocache)
    );

    // Resolve the outcome of the current request by priority.
    always_comb begin
        n_valid = req_valid;
        n_paddr = '0;
        n_cache = 1'b0;
        n_hit   = 1'b0;
        n_miss  = 1'b0;
        n_mod   = 1'b0;
        n_af    = 1'b0;
        n_multi = 1'b0;
        if (req_valid) begin
            if (addr_fault) begin
                n_af = 1'b1;
            end else if (!mapped) begin
                n_paddr = bypass_paddr;
                n_cache = bypass_cacheable;
            end else if (!any_hit) begin
                n_miss = 1'b1;
            end else if (req_write && (!hit_rw || !hit_dirty)) begin
                n_mod = 1'b1;
            end else begin
                n_hit   = 1'b1;
                n_paddr = {hit_ppn, req_vaddr[PAGE_W-1:0]};
                n_cache = !hit_nocache;
                n_multi = multi_hit;
            end
        end
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_paddr      <= '0;
            rsp_cacheable  <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_miss       <= 1'b0;
            rsp_mod_fault  <= 1'b0;
            rsp_addr_fault <= 1'b0;
            rsp_multi_hit  <= 1'b0;
        end else begin
            rsp_valid      <= n_valid;
            rsp_paddr      <= n_paddr;
            rsp_cacheable  <= n_cache;
            rsp_hit        <= n_hit;
            rsp_miss       <= n_miss;
            rsp_mod_fault  <= n_mod;
            rsp_addr_fault <= n_af;
            rsp_multi_hit  <= n_multi;
        end
    end
endmodule

// File: rtl/asid_tlb_chk.sv
// Protocol checker for asid_tlb, attached by bind. Observes ports only.
module asid_tlb_chk
    import asid_tlb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            req_write,
    input logic            req_user_mode,
    input logic            flush_all,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_cacheable,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_mod_fault,
    input logic            rsp_addr_fault,
    input logic            rsp_multi_hit
);
    // R10: a sampled request yields a response next cycle.
    a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10: no request means quiet outputs next cycle.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && !rsp_mod_fault &&
                        !rsp_addr_fault && rsp_paddr == '0));

    // R3: at most one outcome flag per response.
    a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_miss, rsp_mod_fault, rsp_addr_fault}));

    // R9: a multi-match is only reported alongside a hit.
    a_r9_multi_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi_hit |-> rsp_hit);

    // R1: direct kernel windows pass the address through.
    a_r1_bypass_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_user_mode && req_vaddr[VA_W-1 -: 2] == 2'b10) |=>
        (rsp_paddr == PA_W'($past(req_vaddr[VA_W-4:0])) &&
         rsp_cacheable == !$past(req_vaddr[VA_W-3]) && !rsp_hit && !rsp_miss));

    // R5: user access to kernel space faults.
    a_r5_user_kernel_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user_mode && req_vaddr[VA_W-1]) |=>
        (rsp_addr_fault && rsp_paddr == '0));

    // R4: modify faults come only from stores.
    a_r4_mod_only_store: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_mod_fault |-> $past(req_write));

    // R8: a user-region lookup right after a flush misses.
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all ##1 (req_valid && !req_vaddr[VA_W-1]) |=> rsp_miss);
endmodule

bind asid_tlb asid_tlb_chk chk_i (.*);

// File: tb/asid_tlb_tb_top.sv
// Self-checking bench for asid_tlb: directed corners plus seeded random traffic
// against a bench-side reference model.
module asid_tlb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_user_mode = 0;
    logic [31:0] req_vaddr = '0;
    logic [5:0]  req_asid = '0;
    logic        wr_en = 0, wr_random = 0, wr_valid = 0, wr_dirty = 0, wr_rw = 0, wr_nocache = 0;
    logic [5:0]  wr_index = '0, wr_asid = '0;
    logic [19:0] wr_vpn = '0, wr_ppn = '0;
    logic        flush_all = 0;
    logic        rsp_valid, rsp_cacheable, rsp_hit, rsp_miss, rsp_mod_fault, rsp_addr_fault, rsp_multi_hit;
    logic [31:0] rsp_paddr;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // Reference model state.
    bit         m_valid [64];
    bit [5:0]   m_asid  [64];
    bit [19:0]  m_vpn   [64];
    bit [19:0]  m_ppn   [64];
    bit         m_dirty [64];
    bit         m_rw    [64];
    bit         m_nc    [64];
    logic [5:0] cnt_m;

    always #5 clk = ~clk;

    // Victim counter as specified: 0 after reset, +1 per clock.
    always @(posedge clk) begin
        if (!rst_n) cnt_m <= '0;
        else        cnt_m <= cnt_m + 6'd1;
    end

    asid_tlb dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .req_user_mode(req_user_mode), .req_asid(req_asid),
        .wr_en(wr_en), .wr_random(wr_random), .wr_index(wr_index),
        .wr_valid(wr_valid), .wr_asid(wr_asid), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .wr_dirty(wr_dirty), .wr_rw(wr_rw), .wr_nocache(wr_nocache),
        .flush_all(flush_all),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_cacheable(rsp_cacheable),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_mod_fault(rsp_mod_fault),
        .rsp_addr_fault(rsp_addr_fault), .rsp_multi_hit(rsp_multi_hit)
    );

    function automatic logic [38:0] act_vec();
        return {rsp_valid, rsp_paddr, rsp_cacheable, rsp_hit, rsp_miss,
                rsp_mod_fault, rsp_addr_fault, rsp_multi_hit};
    endfunction

    // Expected response from the requirements; also returns a tag.
    function automatic logic [38:0] expect_rsp(input logic [31:0] va, input logic w, um,
                                               input logic [5:0] asid, output string tag);
        logic [31:0] pa = '0;
        logic cache = 0, hit = 0, miss = 0, mod = 0, af = 0, multi = 0;
        int first = -1, n = 0;
        if (um && va[31]) begin
            af = 1; tag = "R5";
        end else if (va[31:30] == 2'b10) begin
            pa = {3'b000, va[28:0]}; cache = !va[29]; tag = "R1";
        end else begin
            for (int i = 0; i < 64; i++)
                if (m_valid[i] && m_asid[i] == asid && m_vpn[i] == va[31:12]) begin
                    if (first < 0) first = i;
                    n++;
                end
            if (first < 0) begin
                miss = 1; tag = "R3";
            end else if (w && (!m_rw[first] || !m_dirty[first])) begin
                mod = 1; tag = "R4";
            end else begin
                hit = 1; pa = {m_ppn[first], va[11:0]}; cache = !m_nc[first];
                multi = (n > 1); tag = multi ? "R9" : "R2";
            end
        end
        return {1'b1, pa, cache, hit, miss, mod, af, multi};
    endfunction

    task automatic check_vec(input string req, input logic [38:0] act, input logic [38:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Lookup: drive on a falling edge, compare on the next falling edge.
    task automatic lookup(input logic [31:0] va, input logic w, um, input logic [5:0] asid,
                          input string req);
        string tag;
        logic [38:0] exp = expect_rsp(va, w, um, asid, tag);
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_write = w; req_user_mode = um; req_asid = asid;
        @(negedge clk);
        req_valid = 0;
        check_vec((req == "") ? tag : req, act_vec(), exp);
    endtask

    task automatic refill(input bit rnd, input logic [5:0] idx, input bit v, input logic [5:0] asid,
                          input logic [19:0] vpn, ppn, input bit d, rw, nc);
        int s;
        @(negedge clk);
        wr_en = 1; wr_random = rnd; wr_index = idx; wr_valid = v; wr_asid = asid;
        wr_vpn = vpn; wr_ppn = ppn; wr_dirty = d; wr_rw = rw; wr_nocache = nc;
        s = rnd ? int'(cnt_m) : int'(idx);
        m_valid[s] = v; m_asid[s] = asid; m_vpn[s] = vpn; m_ppn[s] = ppn;
        m_dirty[s] = d; m_rw[s] = rw; m_nc[s] = nc;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic flush(input bit with_write);
        @(negedge clk);
        flush_all = 1;
        if (with_write) begin
            wr_en = 1; wr_random = 0; wr_index = 6'd5; wr_valid = 1; wr_asid = 6'd2;
            wr_vpn = 20'h00055; wr_ppn = 20'h12345; wr_dirty = 1; wr_rw = 1; wr_nocache = 0;
        end
        for (int i = 0; i < 64; i++) m_valid[i] = 0;
        @(negedge clk);
        flush_all = 0; wr_en = 0;
    endtask

    function automatic logic [19:0] pool_vpn(input int k);
        return {(k[3] ? 3'b110 : 3'b000), 14'd0, k[2:0]};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        string tag;
        logic [38:0] exp;
        for (int i = 0; i < 64; i++) m_valid[i] = 0;
        void'($urandom(32'd7215));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R11: outputs cleared by reset
        check_vec("R11", act_vec(), 39'd0);
        lookup(32'h0000_1234, 0, 0, 6'd0, "R11");

        // R1: direct kernel windows
        lookup(32'h8123_4567, 0, 0, 6'd3, "R1");
        lookup(32'hA765_4321, 1, 0, 6'd3, "R1");
        // R5: user mode into kernel space
        lookup(32'h8000_0010, 0, 1, 6'd0, "R5");
        lookup(32'hC000_0010, 1, 1, 6'd0, "R5");

        // R2 / R6: indexed refill then hit, ASID mismatch misses (R3)
        refill(0, 6'd10, 1, 6'd4, 20'h00012, 20'hABCDE, 1, 1, 0);
        lookup(32'h0001_2FFC, 1, 1, 6'd4, "R2");
        lookup(32'h0001_2FFC, 0, 0, 6'd5, "R3");
        refill(0, 6'd11, 1, 6'd4, 20'hC0003, 20'h00777, 1, 1, 1);
        lookup(32'hC000_3008, 0, 0, 6'd4, "R2");
        // R4: read-only and clean pages
        refill(0, 6'd12, 1, 6'd4, 20'h00020, 20'h00111, 1, 0, 0);
        lookup(32'h0002_0000, 1, 0, 6'd4, "R4");
        lookup(32'h0002_0000, 0, 0, 6'd4, "R4");
        refill(0, 6'd13, 1, 6'd4, 20'h00021, 20'h00112, 0, 1, 0);
        lookup(32'h0002_1000, 1, 0, 6'd4, "R4");
        // R6: invalidate by writing a cleared valid bit
        refill(0, 6'd10, 0, 6'd4, 20'h00012, 20'hABCDE, 1, 1, 0);
        lookup(32'h0001_2000, 0, 0, 6'd4, "R6");
        // R9: duplicates, lowest index wins
        refill(0, 6'd40, 1, 6'd1, 20'h00099, 20'h00A40, 1, 1, 0);
        refill(0, 6'd20, 1, 6'd1, 20'h00099, 20'h00A20, 1, 1, 0);
        lookup(32'h0009_9044, 0, 0, 6'd1, "R9");

        // R10: refill and lookup on one edge sees old contents, then new
        @(negedge clk);
        exp = expect_rsp(32'h0003_3000, 0, 0, 6'd1, tag);
        req_valid = 1; req_vaddr = 32'h0003_3000; req_write = 0; req_user_mode = 0; req_asid = 6'd1;
        wr_en = 1; wr_random = 0; wr_index = 6'd30; wr_valid = 1; wr_asid = 6'd1;
        wr_vpn = 20'h00033; wr_ppn = 20'h00F00; wr_dirty = 1; wr_rw = 1; wr_nocache = 0;
        m_valid[30] = 1; m_asid[30] = 6'd1; m_vpn[30] = 20'h00033; m_ppn[30] = 20'h00F00;
        m_dirty[30] = 1; m_rw[30] = 1; m_nc[30] = 0;
        @(negedge clk);
        req_valid = 0; wr_en = 0;
        check_vec("R10", act_vec(), exp);
        lookup(32'h0003_3ABC, 0, 0, 6'd1, "R10");
        @(negedge clk);
        check_vec("R10", act_vec(), 39'd0);

        // R7: fill every slot, then a random refill replaces the counter slot
        for (int i = 0; i < 64; i++)
            refill(0, 6'(i), 1, 6'd2, 20'h00100 + 20'(i), 20'h10000 + 20'(i), 1, 1, 0);
        begin
            int s;
            @(negedge clk);
            s = int'(cnt_m);
            wr_en = 1; wr_random = 1; wr_index = 6'(s + 7); wr_valid = 1; wr_asid = 6'd2;
            wr_vpn = 20'h00200; wr_ppn = 20'h20000; wr_dirty = 1; wr_rw = 1; wr_nocache = 1;
            m_vpn[s] = 20'h00200; m_ppn[s] = 20'h20000; m_nc[s] = 1;
            @(negedge clk);
            wr_en = 0;
            lookup({20'h00100 + 20'(s), 12'h010}, 0, 0, 6'd2, "R7");
            lookup(32'h0020_0010, 0, 0, 6'd2, "R7");
            lookup({20'h00100 + 20'((s + 7) % 64), 12'h010}, 0, 0, 6'd2, "R7");
        end

        // R8: flush with a simultaneous refill
        flush(1);
        lookup(32'h0005_5000, 0, 0, 6'd2, "R8");
        lookup(32'h0010_0000, 0, 0, 6'd2, "R8");

        // Seeded random traffic
        for (int it = 0; it < 600; it++) begin
            int op = $urandom % 20;
            if (op < 5)
                refill(0, 6'($urandom), ($urandom % 8) != 0, 6'($urandom % 2),
                       pool_vpn($urandom % 16), 20'($urandom), $urandom, $urandom, $urandom);
            else if (op < 7)
                refill(1, 6'd0, 1, 6'($urandom % 2), pool_vpn($urandom % 16),
                       20'($urandom), $urandom, $urandom, $urandom);
            else if (op == 7 && ($urandom % 6) == 0)
                flush(0);
            else begin
                logic [31:0] va = {pool_vpn($urandom % 16), 12'($urandom)};
                if (($urandom % 4) == 0) va[31:29] = 3'($urandom);
                lookup(va, $urandom, ($urandom % 5) == 0, 6'($urandom % 2), "");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule